// File: doc/BRIEF.md
# USB Test-Mode Control Register

This block is the 8-bit test-mode register of a USB OTG controller. Software uses it to put the controller into special operating conditions during compliance and bring-up work. Three fields are defined, and the positions of the live bits are fixed because software decodes them. Bit 7 forces host operation, and it exists only while the controller plays the host role. Bit 6 is a write-one-to-set trigger that asks an external copy engine to move one packet from the endpoint 0 transmit FIFO into the endpoint 0 receive FIFO. Bit 5 selects full speed, and that choice takes effect at the next bus reset.

The forced-host tracker enters host mode when a session starts while forcing is enabled. It does not consult the D+ and D- line states for this. It stays in host mode through peer disconnects until the session ends. If the force bit is still set when the next session starts, it enters host mode again. Setting more than one test bit in a single write is not refused. The write is stored as given, and a sticky error flag reports the misuse.

Top module: `usb_testmode_ctl`

## Requirements
- R1: After reset, rd_data is 0x00, and host_mode, full_speed, xfer_start and multi_err are all 0.
- R2: In host role (role_host=1), bit 7 (force host) and bit 5 (force full speed) are read/write. Bits 4..0 always read 0, whatever is written to them.
- R3: In device role (role_host=0), bit 7 reads 0, and a write does not change the stored force-host value. A stored force-host bit has no effect in device role.
- R4: Writing 1 to bit 6 while no transfer is pending makes bit 6 read 1 from the next cycle. In that same cycle xfer_start is high, for exactly one cycle. Writing 0 to bit 6 has no effect.
- R5: While a transfer is pending, a new write of 1 to bit 6 produces no xfer_start. When xfer_done is sampled high on a clock edge, bit 6 reads 0 from the cycle after that edge.
- R6: When force host is effective and session rises, host_mode goes to 1 on the next cycle. This holds for any level of line_dp and line_dm, including both low (no peer).
- R7: Once in host mode, host_mode stays 1 while session is high, whatever the line states do. It drops to 0 in the same cycle that session falls.
- R8: If force host is still 1 at the next rising edge of session, host mode is entered again. If force host is 0 at that edge, host_mode stays 0.
- R9: full_speed takes the value of bit 5 only on a rising edge of bus_reset. Changing bit 5 between resets leaves full_speed unchanged, and a bus_reset held high does not capture again.
- R10: A write that requests more than one of the test bits stores all fields as written and sets multi_err. multi_err then stays 1 until reset. In device role, bit 7 does not count as a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register read value |
| role_host | input | 1 | 1 = host role, 0 = device role |
| session | input | 1 | Session-valid level |
| bus_reset | input | 1 | Bus reset indication; its rising edge captures the speed |
| line_dp | input | 1 | D+ line state (not used for the forced-host decision) |
| line_dm | input | 1 | D- line state (not used for the forced-host decision) |
| xfer_start | output | 1 | One-cycle request to the FIFO copy engine |
| xfer_done | input | 1 | Copy engine completion |
| host_mode | output | 1 | Forced host mode is active |
| full_speed | output | 1 | Captured speed selection: 1 = full, 0 = low |
| multi_err | output | 1 | Sticky flag for a multi-bit test request |

## Verification
The fields are stored in registers, but the read path is combinational, so a wrongly stored bit shows on rd_data in the cycle after the write. A pending flag that is stuck or cleared too early shows one cycle after the write or after xfer_done, either as a missing or repeated xfer_start or as a wrong bit 6. A tracker that keeps stale state shows on host_mode, one cycle after a session rise or immediately after a session fall. A speed latch that follows the bit instead of the reset edge shows on full_speed as soon as bit 5 is rewritten between resets.

// File: rtl/usbtm_pkg.sv
package usbtm_pkg;
  // Bit positions decoded by software
  localparam int BIT_FH   = 7;
  localparam int BIT_FIFO = 6;
  localparam int BIT_FFS  = 5;

  typedef enum logic {
    HF_IDLE = 1'b0,
    HF_HOST = 1'b1
  } hf_state_e;

  // Number of test bits requested by a write
  function automatic logic [1:0] count_test_bits(input logic fh, input logic fifo,
                                                 input logic ffs);
    return {1'b0, fh} + {1'b0, fifo} + {1'b0, ffs};
  endfunction
endpackage

// File: rtl/tm_regfile.sv
module tm_regfile
  import usbtm_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             role_host,
  input  logic             fifo_pending,
  output logic             force_host,
  output logic             force_fs,
  output logic             multi_err,
  output logic [REG_W-1:0] rd_data
);
  logic fh_q, ffs_q, err_q;
  logic fh_wr;
  logic multi_req;
  logic unused_rsvd;

  assign fh_wr     = wr_en && role_host;
  assign multi_req = wr_en &&
                     (count_test_bits(role_host && wr_data[BIT_FH], wr_data[BIT_FIFO],
                                      wr_data[BIT_FFS]) > 2'd1);
  assign unused_rsvd = ^wr_data[BIT_FFS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fh_q  <= 1'b0;
      ffs_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (fh_wr) fh_q <= wr_data[BIT_FH];
      if (wr_en) ffs_q <= wr_data[BIT_FFS];
      if (multi_req) err_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data           = '0;
    rd_data[BIT_FH]   = fh_q && role_host;
    rd_data[BIT_FIFO] = fifo_pending;
    rd_data[BIT_FFS]  = ffs_q;
  end

  assign force_host = fh_q && role_host;
  assign force_fs   = ffs_q;
  assign multi_err  = err_q;

  // R3
  dev_fh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !role_host) |=> $stable(fh_q));
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/tm_fifo_xfer.sv
module tm_fifo_xfer (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic xfer_done,
  output logic pending,
  output logic xfer_start
);
  logic pend_q, start_q;
  logic accept, finish;

  assign accept = set_req && !pend_q;
  assign finish = xfer_done && pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= accept;
      if (accept)      pend_q <= 1'b1;
      else if (finish) pend_q <= 1'b0;
    end
  end

  assign pending    = pend_q;
  assign xfer_start = start_q;

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R5
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && set_req) |=> !start_q);
  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !pend_q);
endmodule

// File: rtl/tm_host_force.sv
module tm_host_force
  import usbtm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic force_en,
  input  logic session,
  input  logic line_dp,
  input  logic line_dm,
  output logic host_mode
);
  hf_state_e st_q;
  logic sess_q;
  logic sess_rise;
  logic unused_line_state;

  assign sess_rise = session && !sess_q;
  // Forced entry deliberately ignores the line state
  assign unused_line_state = line_dp ^ line_dm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HF_IDLE;
      sess_q <= 1'b0;
    end else begin
      sess_q <= session;
      case (st_q)
        HF_IDLE: if (sess_rise && force_en) st_q <= HF_HOST;
        HF_HOST: if (!session) st_q <= HF_IDLE;
        default: st_q <= HF_IDLE;
      endcase
    end
  end

  assign host_mode = (st_q == HF_HOST) && session;

  // R6
  forced_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_en && sess_rise && !line_dp && !line_dm) |=> (st_q == HF_HOST));
  // R7
  host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == HF_HOST) && session) |=> (st_q == HF_HOST));
  // R7
  sess_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !session |-> !host_mode);
endmodule

// File: rtl/tm_speed_latch.sv
module tm_speed_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic force_fs,
  output logic full_speed
);
  logic rst_q, fs_q;
  logic reset_rise;

  assign reset_rise = bus_reset && !rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      fs_q  <= 1'b0;
    end else begin
      rst_q <= bus_reset;
      if (reset_rise) fs_q <= force_fs;
    end
  end

  assign full_speed = fs_q;

  // R9
  speed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reset_rise |=> $stable(fs_q));
endmodule

// File: rtl/usb_testmode_ctl.sv
module usb_testmode_ctl
  import usbtm_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             role_host,
  input  logic             session,
  input  logic             bus_reset,
  input  logic             line_dp,
  input  logic             line_dm,
  output logic             xfer_start,
  input  logic             xfer_done,
  output logic             host_mode,
  output logic             full_speed,
  output logic             multi_err
);
  logic force_host, force_fs, fifo_pending;
  logic fifo_set;

  assign fifo_set = wr_en && wr_data[BIT_FIFO];

  tm_regfile #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .role_host(role_host), .fifo_pending(fifo_pending),
    .force_host(force_host), .force_fs(force_fs),
    .multi_err(multi_err), .rd_data(rd_data)
  );

  tm_fifo_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .set_req(fifo_set), .xfer_done(xfer_done),
    .pending(fifo_pending), .xfer_start(xfer_start)
  );

  tm_host_force u_host (
    .clk(clk), .rst_n(rst_n), .force_en(force_host), .session(session),
    .line_dp(line_dp), .line_dm(line_dm), .host_mode(host_mode)
  );

  tm_speed_latch u_speed (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .force_fs(force_fs),
    .full_speed(full_speed)
  );

  // R4
  start_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> rd_data[BIT_FIFO]);
endmodule

// File: tb/test_usb_testmode_ctl.sv
`timescale 1ns/1ps
module test_usb_testmode_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       role_host = 1'b1;
  logic       session = 1'b0;
  logic       bus_reset = 1'b0;
  logic       line_dp = 1'b0;
  logic       line_dm = 1'b0;
  logic       xfer_start;
  logic       xfer_done = 1'b0;
  logic       host_mode;
  logic       full_speed;
  logic       multi_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  usb_testmode_ctl i_usb_testmode_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .role_host(role_host), .session(session), .bus_reset(bus_reset),
    .line_dp(line_dp), .line_dm(line_dm), .xfer_start(xfer_start),
    .xfer_done(xfer_done), .host_mode(host_mode), .full_speed(full_speed),
    .multi_err(multi_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic t_reset();
    chk_eq("R1 rd_data", rd_data, 8'h00);
    chk_eq("R1 host_mode", host_mode, 0);
    chk_eq("R1 full_speed", full_speed, 0);
    chk_eq("R1 xfer_start", xfer_start, 0);
    chk_eq("R1 multi_err", multi_err, 0);
  endtask

  task automatic t_host_rw();
    role_host = 1'b1;
    wr(8'h9F);
    chk_eq("R2 bit7 set, rsvd 0", rd_data, 8'h80);
    wr(8'h2F);
    chk_eq("R2 bit5 set, rsvd 0", rd_data, 8'h20);
    wr(8'h00);
    chk_eq("R2 cleared", rd_data, 8'h00);
  endtask

  task automatic t_device_role();
    role_host = 1'b1;
    wr(8'h80);
    @(negedge clk) role_host = 1'b0;
    #1 chk_eq("R3 bit7 hidden in device role", rd_data, 8'h00);
    @(negedge clk) session = 1'b1;
    @(negedge clk);
    chk_eq("R3 no forced host in device role", host_mode, 0);
    session = 1'b0;
    role_host = 1'b1;
    wr(8'h00);
    role_host = 1'b0;
    wr(8'h80);
    role_host = 1'b1;
    #1 chk_eq("R3 device write left bit7 clear", rd_data, 8'h00);
    chk_eq("R10 lone bit7 in device role no error", multi_err, 0);
  endtask

  task automatic t_fifo();
    wr(8'h00);
    chk_eq("R4 zero write starts nothing", xfer_start, 0);
    wr(8'h40);
    chk_eq("R4 start pulse", xfer_start, 1);
    chk_eq("R4 bit6 pending", rd_data, 8'h40);
    @(negedge clk);
    chk_eq("R4 start one cycle", xfer_start, 0);
    wr(8'h40);
    chk_eq("R5 rewrite while pending ignored", xfer_start, 0);
    wr(8'h00);
    chk_eq("R4 zero write keeps pending", rd_data, 8'h40);
    @(negedge clk) xfer_done = 1'b1;
    chk_eq("R5 pending before done edge", rd_data[6], 1);
    @(negedge clk) xfer_done = 1'b0;
    chk_eq("R5 cleared after done", rd_data[6], 0);
    chk_eq("R5 no start on done", xfer_start, 0);
  endtask

  task automatic t_force_host();
    role_host = 1'b1;
    line_dp = 1'b0;
    line_dm = 1'b0;
    wr(8'h80);
    @(negedge clk) session = 1'b1;
    #1 chk_eq("R6 not yet in host", host_mode, 0);
    @(negedge clk);
    chk_eq("R6 entered with SE0 lines", host_mode, 1);
    line_dp = 1'b1;
    @(negedge clk);
    line_dp = 1'b0;
    @(negedge clk);
    chk_eq("R7 held through disconnect", host_mode, 1);
    session = 1'b0;
    #1 chk_eq("R7 drops with session", host_mode, 0);
    @(negedge clk);
    line_dm = 1'b1;
    session = 1'b1;
    @(negedge clk);
    chk_eq("R8 re-entered next session", host_mode, 1);
    session = 1'b0;
    line_dm = 1'b0;
    wr(8'h00);
    @(negedge clk) session = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_eq("R8 no entry after clear", host_mode, 0);
    session = 1'b0;
  endtask

  task automatic t_speed();
    wr(8'h20);
    chk_eq("R9 no capture without reset", full_speed, 0);
    @(negedge clk) bus_reset = 1'b1;
    @(negedge clk);
    chk_eq("R9 captured full speed", full_speed, 1);
    wr(8'h00);
    @(negedge clk);
    chk_eq("R9 held while reset high", full_speed, 1);
    bus_reset = 1'b0;
    @(negedge clk);
    chk_eq("R9 held after bit cleared", full_speed, 1);
    bus_reset = 1'b1;
    @(negedge clk);
    chk_eq("R9 captured low speed", full_speed, 0);
    bus_reset = 1'b0;
  endtask

  task automatic t_multi();
    chk_eq("R10 no error before misuse", multi_err, 0);
    wr(8'hA0);
    chk_eq("R10 stored as written", rd_data, 8'hA0);
    chk_eq("R10 error raised", multi_err, 1);
    wr(8'h00);
    chk_eq("R10 error sticky", multi_err, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_host_rw();
    t_device_role();
    t_fifo();
    t_force_host();
    t_speed();
    t_multi();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule